// File: doc/BRIEF.md
# Conversion Result Buffer with Clear Command

This block sits between an analog-to-digital converter and a host that has an 8-bit register bus. Each finished conversion delivers a 16-bit result, which is queued in a small first-in first-out store. The host drains every result with two byte reads of one data port. The low byte comes first. The second read advances the queue.

Two sticky error flags are kept beside the data. One records a result that was lost because the store was full. The other records a new conversion start that arrived while the previous conversion was still in progress. An interrupt request tells the host that fresh results are waiting, and an enable bit gates it. A write strobe on the clear port resets both flags and any pending interrupt. It also abandons a conversion in flight. After a clear the store holds exactly one meaningless word. The host discards it with two data reads before it starts new conversions. After that, every word read comes from a conversion started after the clear.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt output is low, and the interrupt enable is off.
- R2: Results come out in the order their conversions completed. The store holds up to DEPTH (16) results.
- R3: A result is delivered as two reads of the data port. Before the first read the data byte shows bits 7:0. Before the second read it shows bits 15:8. The second read removes the word.
- R4: Status bit 0 is 1 whenever the store holds at least one word. Bits 7:3 always read 0.
- R5: A completion that arrives while the store is full, with no word leaving in the same cycle, sets status bit 1 (overflow). The result is discarded. The flag stays set until a clear.
- R6: A start strobe that arrives while a conversion is outstanding sets status bit 2 (overrun), unless a completion arrives in the same cycle. The flag stays set until a clear.
- R7: A completion strobe with no outstanding conversion is ignored.
- R8: The interrupt output is high only when the enable bit is set (bit 0 of a control write) and a result has been stored since the store was last empty or cleared. It falls once the store empties.
- R9: A clear write resets both error flags and the pending interrupt. The interrupt enable keeps its value.
- R10: After a clear the store holds exactly one word, so status bit 0 is 1. Two data reads remove that word and empty the store.
- R11: A clear abandons an outstanding conversion. Its later completion stores nothing.
- R12: A data read while the store is empty has no effect on the byte order of the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| conv_start | input | 1 | Pulse: a conversion has begun |
| conv_done | input | 1 | Pulse: conversion finished, result on conv_data |
| conv_data | input | 16 | Conversion result |
| clr_wr | input | 1 | Pulse: host write to the clear register |
| ctrl_wr | input | 1 | Pulse: host write to the control register |
| ctrl_wdata | input | 8 | Control write data, bit 0 = interrupt enable |
| data_rd | input | 1 | Pulse: host read of the data port |
| data_byte | output | 8 | Byte currently presented by the data port |
| status_byte | output | 8 | Bit 0 data available, bit 1 overflow, bit 2 overrun |
| irq | output | 1 | Interrupt request |

## Verification
Result words with distinct high and low bytes are pushed one at a time, in bursts, and up to and past a full store. A byte swap, a lost word or a misplaced pointer wrap then shows up as a scoreboard mismatch. Strobe patterns separate a true overrun, a start paired with a completion in the same cycle, and a completion with no start. A clear is issued around an in-flight conversion to show that the stale word and the abandoned result stay apart. Reads of an empty store check that the byte order of the next word is unchanged.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
  localparam int ST_AVAIL = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_OVR   = 2;

  // next index of a circular pointer
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of push/pop
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int BW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          rd_strobe,
  output logic [BW-1:0] rd_byte,
  output logic          empty,
  output logic          full,
  output logic          last_word,
  output logic          pop
);
  import adc_buf_pkg::*;
  localparam int NLANE = DW / BW;
  localparam int LW    = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [LW-1:0] lane;
  logic          lane_last;
  logic [BW-1:0] lane_bytes [NLANE];

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign last_word = (count == CW'(1));
  assign lane_last = (lane == LW'(NLANE - 1));
  assign pop       = rd_strobe && !empty && lane_last && !clear;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_bytes[g] = mem[rd_ptr][g*BW +: BW];
  end
  assign rd_byte = lane_bytes[lane];

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      lane   <= '0;
    end else if (clear) begin
      // one stale word left at the head
      rd_ptr <= '0;
      wr_ptr <= AW'(wrap_inc(0, DEPTH));
      count  <= CW'(1);
      lane   <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= CW'(occ_next(int'(count), push, pop));
      if (rd_strobe && !empty) lane <= lane_last ? '0 : lane + LW'(1);
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R10
  clear_leaves_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == CW'(1)) && (lane == '0));
  // R2
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |=> count == $past(count) + CW'(1));
  // R12
  empty_read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !clear) |=> $stable(lane));
endmodule

// File: rtl/adc_err_flags.sv
module adc_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic conv_start,
  input  logic conv_done,
  input  logic fifo_full,
  input  logic fifo_pop,
  output logic accept,
  output logic ovf_flag,
  output logic ovr_flag
);
  logic busy;
  logic done_ok, ovf_event, ovr_event;

  assign done_ok   = conv_done && busy && !clear;
  assign accept    = done_ok && (!fifo_full || fifo_pop);
  assign ovf_event = done_ok && fifo_full && !fifo_pop;
  assign ovr_event = conv_start && busy && !conv_done && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ovf_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else if (clear) begin
      busy     <= 1'b0;
      ovf_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (conv_start)     busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      if (ovf_event) ovf_flag <= 1'b1;
      if (ovr_event) ovr_flag <= 1'b1;
    end
  end

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ovf_flag && !ovr_flag);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clear) |=> ovf_flag);
  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clear) |=> ovr_flag);
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic push,
  input  logic pop,
  input  logic last_word,
  input  logic fifo_empty,
  input  logic ctrl_wr,
  input  logic ctrl_en_bit,
  output logic irq
);
  logic pend, en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (ctrl_wr) en <= ctrl_en_bit;
      if (clear)                 pend <= 1'b0;
      else if (push)             pend <= 1'b1;
      else if (pop && last_word) pend <= 1'b0;
    end
  end

  assign irq = pend && en;

  // R8
  pend_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !fifo_empty);
  // R9
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend);
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_start,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          clr_wr,
  input  logic          ctrl_wr,
  input  logic [BW-1:0] ctrl_wdata,
  input  logic          data_rd,
  output logic [BW-1:0] data_byte,
  output logic [BW-1:0] status_byte,
  output logic          irq
);
  import adc_buf_pkg::*;

  logic push_ev, pop_ev, fifo_empty, fifo_full, last_word;
  logic ovf_flag, ovr_flag;

  adc_err_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clear(clr_wr),
    .conv_start(conv_start), .conv_done(conv_done),
    .fifo_full(fifo_full), .fifo_pop(pop_ev),
    .accept(push_ev), .ovf_flag(ovf_flag), .ovr_flag(ovr_flag)
  );

  adc_res_fifo #(.DEPTH(DEPTH), .DW(DW), .BW(BW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clr_wr),
    .push(push_ev), .push_data(conv_data),
    .rd_strobe(data_rd), .rd_byte(data_byte),
    .empty(fifo_empty), .full(fifo_full), .last_word(last_word), .pop(pop_ev)
  );

  adc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .clear(clr_wr),
    .push(push_ev), .pop(pop_ev), .last_word(last_word), .fifo_empty(fifo_empty),
    .ctrl_wr(ctrl_wr), .ctrl_en_bit(ctrl_wdata[0]), .irq(irq)
  );

  always_comb begin
    status_byte           = '0;
    status_byte[ST_AVAIL] = !fifo_empty;
    status_byte[ST_OVF]   = ovf_flag;
    status_byte[ST_OVR]   = ovr_flag;
  end

  // R7
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !push_ev && !clr_wr) |=> fifo_empty);
endmodule

// File: tb/test_adc_result_buffer.sv
module test_adc_result_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 0, conv_done = 0, clr_wr = 0, ctrl_wr = 0, data_rd = 0;
  logic [15:0] conv_data = '0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  data_byte, status_byte;
  logic        irq;

  int checks = 0, errors = 0;
  bit busy_m = 0, ovf_m = 0, ovr_m = 0;
  logic [15:0] sb_q[$];

  always #10 clk = ~clk;

  adc_result_buffer i_adc_result_buffer (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .clr_wr(clr_wr), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .data_rd(data_rd), .data_byte(data_byte),
    .status_byte(status_byte), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {5'b0, ovr_m, ovf_m, (sb_q.size() != 0)};
  endfunction

  task automatic chk_status(input string req);
    check(status_byte == exp_status(), req, status_byte, exp_status());
  endtask

  task automatic start_conv();
    conv_start = 1; @(negedge clk); conv_start = 0;
    if (busy_m) ovr_m = 1;
    busy_m = 1;
  endtask

  // driver: completion pushes the expected word into the scoreboard
  task automatic finish_conv(input logic [15:0] d);
    conv_done = 1; conv_data = d; @(negedge clk); conv_done = 0;
    if (busy_m) begin
      if (sb_q.size() < 16) sb_q.push_back(d);
      else ovf_m = 1;
    end
    busy_m = 0;
  endtask

  task automatic convert(input logic [15:0] d);
    start_conv(); finish_conv(d);
  endtask

  task automatic read_byte(output logic [7:0] b);
    b = data_byte; data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  // monitor: assemble a word and compare with the scoreboard head
  task automatic read_word(input string req);
    logic [7:0] lo, hi;
    logic [15:0] exp;
    read_byte(lo); read_byte(hi);
    exp = sb_q.pop_front();
    check({hi, lo} == exp, req, {hi, lo}, exp);
  endtask

  task automatic do_clear();
    clr_wr = 1; @(negedge clk); clr_wr = 0;
    ovf_m = 0; ovr_m = 0; busy_m = 0;
    sb_q.delete(); sb_q.push_back(16'h0);  // stale word placeholder
  endtask

  task automatic drain_stale();
    logic [7:0] b;
    read_byte(b); read_byte(b);
    void'(sb_q.pop_front());
  endtask

  task automatic set_irq_en(input bit e);
    ctrl_wdata = {7'b0, e}; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(status_byte == 8'h00, "R1 status", status_byte, 0);
    check(irq == 0, "R1 irq", irq, 0);

    // R2 R3 order and byte lanes
    convert(16'hA155); convert(16'h3CC3); convert(16'h0FF0);
    chk_status("R4 avail");
    check(data_byte == 8'h55, "R3 low byte first", data_byte, 8'h55);
    read_byte(b);
    check(data_byte == 8'hA1, "R3 high byte second", data_byte, 8'hA1);
    read_byte(b);
    void'(sb_q.pop_front());
    read_word("R2 order"); read_word("R2 order");
    chk_status("R4 empty");

    // R5 fill and overflow
    for (int i = 0; i < 16; i++) convert(16'h1000 + 16'(i * 16'h0111));
    chk_status("R2 full");
    convert(16'hDEAD);
    chk_status("R5 overflow set");
    for (int i = 0; i < 16; i++) read_word("R5 no loss");
    chk_status("R5 sticky after drain");

    // R6 overrun and start/done same cycle
    do_clear(); drain_stale();
    start_conv();
    conv_start = 1; conv_done = 1; conv_data = 16'h1234; @(negedge clk);
    conv_start = 0; conv_done = 0; sb_q.push_back(16'h1234); busy_m = 1;
    chk_status("R6 no overrun when done coincides");
    start_conv();
    chk_status("R6 overrun set");
    finish_conv(16'h5678);
    read_word("R6 data"); read_word("R6 data");
    chk_status("R6 sticky");

    // R7 done without start
    finish_conv(16'hBEEF);
    chk_status("R7 ignored");

    // R8 interrupt
    do_clear(); drain_stale();
    convert(16'h4321);
    check(irq == 0, "R8 masked", irq, 0);
    set_irq_en(1);
    check(irq == 1, "R8 enabled", irq, 1);
    read_word("R8 data");
    check(irq == 0, "R8 falls when empty", irq, 0);

    // R9 R10 clear
    convert(16'h7777);
    start_conv(); start_conv(); finish_conv(16'h8888);
    do_clear();
    chk_status("R9 R10 flags cleared stale word present");
    check(irq == 0, "R9 irq dropped", irq, 0);
    drain_stale();
    chk_status("R10 empty after two reads");
    convert(16'h2468);
    check(irq == 1, "R9 enable kept", irq, 1);
    read_word("R9 data");

    // R11 abandoned conversion
    start_conv(); do_clear(); finish_conv(16'h9999);
    drain_stale();
    chk_status("R11 abandoned result not stored");

    // R12 empty read ignored
    read_byte(b);
    convert(16'hC35A);
    check(data_byte == 8'h5A, "R12 lane intact", data_byte, 8'h5A);
    read_word("R12 data");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule